// File: doc/BRIEF.md
# Three-Pair Complementary PWM Generator with Dead-Time Insertion

This block drives three half-bridge legs. One shared 10-bit counter, stepped by a prescaled PWM clock, produces a high-side and a low-side drive signal for each leg. Each leg has its own 10-bit duty value. A 2-bit resolution code divides the count into a short modulation sub-cycle and a dither index. The upper duty bits set the base pulse width in every sub-cycle. The lower duty bits add one extra clock in a matching number of the sub-cycles, so the average pulse width keeps the full 10-bit resolution while the switching rate goes up.

When a leg changes side, the high-side and low-side drives are separated by a programmable dead gap, measured in system clocks. A polarity option makes the duty value set the width of either the high or the low level on the pins. A master run bit, group enables for all high-side and all low-side drives, and per-pin pass bits gate the outputs. Duty values written through a simple byte-wide write port take effect either at once or only at the boundary of the full PWM cycle. A one-clock interrupt pulse marks the end of each sub-cycle. Fault shutdown, commutation and duty ramping are handled by neighbouring logic through this same write port.

Top module: `cpwm_dt`

## Requirements
- R1: Register map (address: contents). Address 0 is the control register: bit0 run, bit1 high-side group enable, bit2 low-side group enable, bit3 dead-time enable, bit4 low-active polarity, bit5 buffered duty update, bits7:6 dither code k (0..3). Address 1 is the timing register: bits2:0 prescale code, bits4:3 dead-time clock code, bits7:5 dead-time length code. Address 2 holds the pass bits: bit 2p passes the high-side pin of leg p and bit 2p+1 passes its low-side pin. Addresses 4+2p and 5+2p hold the duty of leg p: the first holds D9..D2 and bits1:0 of the second hold D1..D0. After reset every register and every pin is 0 and irq is low.
- R2: The counter advances once every (prescale code + 1) system clocks.
- R3: With dither code k, a sub-cycle lasts 2^(10-k) counts and a full cycle lasts 2^k sub-cycles, which is always 1024 counts.
- R4: In sub-cycle j of a full cycle, the drive of a leg is high for duty[9:k] counts, plus one count when j < duty[k-1:0].
- R5: irq is a single-clock pulse, raised once at the end of every sub-cycle.
- R6: Within an enabled leg, the low-side drive is on exactly when the high-side drive is off, apart from the dead gap. The two drives of a leg are never on together.
- R7: With dead time enabled, every change of side turns the old drive off first. The new drive turns on (length code + 1) << clock code system clocks later. With dead time disabled, the sides swap in the same clock.
- R8: The pin level is the drive state XOR the polarity bit, so a disabled output rests at the polarity level.
- R9: If run is clear, or a group enable is clear, or either pass bit of a leg is clear, both pins of that leg stay at the inactive level. Dead time is applied again when the leg is re-enabled.
- R10: With buffering set, a duty write takes effect only at the next full-cycle boundary. With buffering clear, it takes effect within two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_hi | output | 3 | High-side drive pins, one per leg |
| pwm_lo | output | 3 | Low-side drive pins, one per leg |
| irq | output | 1 | One-clock pulse at each sub-cycle end |

## Verification
On every clock, the assertions check the following: the two drives of a leg are never on together; a drive never turns on in the clock right after its partner was on while dead time is enabled; a gated leg stays off; irq never lasts two clocks; and under buffering the active duty moves only at a full-cycle boundary. The exact numbers can only be shown by the bench scenarios. These are the sub-cycle interrupt period for each dither code and prescale, the dithered pulse-width pattern, the dead-gap length in system clocks, the shortened high-side pulse, the polarity levels, and the cycle in which a rewritten duty appears.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W  = 10;
  localparam int DATA_W = 8;
  localparam int GAP_W  = 7;

  // Drive level for one leg: base width in every sub-cycle plus a dither clock.
  function automatic logic pwm_level(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] duty,
                                     input logic [1:0]       k);
    logic [3:0]       nb;
    logic [CNT_W-1:0] pos, sub, base, ext;
    logic [CNT_W:0]   wid;
    nb   = 4'd10 - {2'b00, k};
    pos  = cnt & (10'h3FF >> k);
    sub  = cnt >> nb;
    base = duty >> k;
    ext  = duty & ~(10'h3FF << k);
    wid  = {1'b0, base} + {10'd0, (sub < ext)};
    return {1'b0, pos} < wid;
  endfunction

  // Dead gap in system clocks: (length + 1) scaled by the dead-time clock divider.
  function automatic logic [GAP_W-1:0] gap_cycles(input logic [2:0] len,
                                                  input logic [1:0] div);
    return ({4'd0, len} + 7'd1) << div;
  endfunction
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PS_W-1:0]  clk_div,
  input  logic [1:0]       ext_bits,
  output logic [CNT_W-1:0] cnt,
  output logic             cycle_end,
  output logic             irq
);
  logic [PS_W-1:0] pre_cnt;
  logic            tick;
  logic            sub_end;
  logic [CNT_W-1:0] pos_mask;

  assign tick      = (pre_cnt >= clk_div);
  assign pos_mask  = 10'h3FF >> ext_bits;
  assign sub_end   = tick && ((cnt & pos_mask) == pos_mask);
  assign cycle_end = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      irq     <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
      irq <= sub_end;
    end
  end
endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int ADDR_W    = 4,
  parameter int PASS_W    = 2 * NUM_PAIRS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            cycle_end,
  output logic [DATA_W-1:0]               ctrl_q,
  output logic [DATA_W-1:0]               time_q,
  output logic [PASS_W-1:0]               pass_q,
  output logic [NUM_PAIRS-1:0][CNT_W-1:0] act_duty
);
  localparam int DUTY_BASE = 4;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] pend_duty;
  logic buf_en;

  assign buf_en = ctrl_q[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      time_q    <= '0;
      pass_q    <= '0;
      pend_duty <= '0;
      act_duty  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(0)) ctrl_q <= wr_data;
      if (wr_en && wr_addr == ADDR_W'(1)) time_q <= wr_data;
      if (wr_en && wr_addr == ADDR_W'(2)) pass_q <= wr_data[PASS_W-1:0];
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (wr_en && wr_addr == ADDR_W'(DUTY_BASE + 2*p))
          pend_duty[p][9:2] <= wr_data;
        if (wr_en && wr_addr == ADDR_W'(DUTY_BASE + 2*p + 1))
          pend_duty[p][1:0] <= wr_data[1:0];
        if (!buf_en || cycle_end)
          act_duty[p] <= pend_duty[p];
      end
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
  import cpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             pair_en,
  input  logic [GAP_W-1:0] gap_load,
  output logic             h_on,
  output logic             l_on
);
  logic             prev;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      gap  <= '0;
      h_on <= 1'b0;
      l_on <= 1'b0;
    end else if (!pair_en) begin
      prev <= raw;
      gap  <= gap_load;
      h_on <= 1'b0;
      l_on <= 1'b0;
    end else if (raw != prev) begin
      prev <= raw;
      gap  <= gap_load;
      h_on <= (gap_load == '0) && raw;
      l_on <= (gap_load == '0) && !raw;
    end else if (gap > GAP_W'(1)) begin
      gap <= gap - 1'b1;
    end else begin
      gap  <= '0;
      h_on <= prev;
      l_on <= !prev;
    end
  end
endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt
  import cpwm_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int ADDR_W    = 4,
  parameter int PS_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_PAIRS-1:0] pwm_hi,
  output logic [NUM_PAIRS-1:0] pwm_lo,
  output logic                 irq
);
  localparam int PASS_W = 2 * NUM_PAIRS;

  logic [DATA_W-1:0]               ctrl_q, time_q;
  logic [PASS_W-1:0]               pass_q;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] act_duty;
  logic [CNT_W-1:0]                cnt;
  logic                            cycle_end;
  logic [NUM_PAIRS-1:0]            raw, pair_en, h_on, l_on;
  logic                            run, hi_en, lo_en, dt_en, pol_low, buf_en;
  logic [1:0]                      ext_bits;
  logic [GAP_W-1:0]                gap_load;

  assign run      = ctrl_q[0];
  assign hi_en    = ctrl_q[1];
  assign lo_en    = ctrl_q[2];
  assign dt_en    = ctrl_q[3];
  assign pol_low  = ctrl_q[4];
  assign buf_en   = ctrl_q[5];
  assign ext_bits = ctrl_q[7:6];
  assign gap_load = dt_en ? gap_cycles(time_q[7:5], time_q[4:3]) : '0;

  cpwm_regs #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .PASS_W(PASS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cycle_end(cycle_end), .ctrl_q(ctrl_q), .time_q(time_q), .pass_q(pass_q),
    .act_duty(act_duty)
  );

  cpwm_timebase #(.PS_W(PS_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .clk_div(time_q[PS_W-1:0]), .ext_bits(ext_bits),
    .cnt(cnt), .cycle_end(cycle_end), .irq(irq)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_leg
    assign raw[p]     = pwm_level(cnt, act_duty[p], ext_bits);
    assign pair_en[p] = run & hi_en & lo_en & pass_q[2*p] & pass_q[2*p+1];
    cpwm_deadband u_db (
      .clk(clk), .rst_n(rst_n), .raw(raw[p]), .pair_en(pair_en[p]),
      .gap_load(gap_load), .h_on(h_on[p]), .l_on(l_on[p])
    );
    assign pwm_hi[p] = h_on[p] ^ pol_low;
    assign pwm_lo[p] = l_on[p] ^ pol_low;
  end
endmodule

// File: rtl/cpwm_dt_checker.sv
module cpwm_dt_checker #(
  parameter int NUM_PAIRS = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_PAIRS-1:0]    h_on,
  input logic [NUM_PAIRS-1:0]    l_on,
  input logic [NUM_PAIRS-1:0]    pair_en,
  input logic                    dt_en,
  input logic                    buf_en,
  input logic                    cycle_end,
  input logic [NUM_PAIRS*10-1:0] act_duty,
  input logic                    irq
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(h_on[p] && l_on[p]));
    a_r7_gap_before_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(h_on[p]) && $past(dt_en)) |-> $past(!l_on[p]));
    a_r7_gap_before_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(l_on[p]) && $past(dt_en)) |-> $past(!h_on[p]));
    a_r9_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pair_en[p]) |-> (!h_on[p] && !l_on[p]));
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r10_hold_until_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(buf_en) && !$past(cycle_end)) |-> $stable(act_duty));
endmodule

bind cpwm_dt cpwm_dt_checker #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_on(h_on), .l_on(l_on), .pair_en(pair_en),
  .dt_en(dt_en), .buf_en(buf_en), .cycle_end(cycle_end), .act_duty(act_duty),
  .irq(irq)
);

// File: tb/cpwm_dt_bench.sv
module cpwm_dt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] pwm_hi, pwm_lo;
  logic       irq;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cpwm_dt u_cpwm_dt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control byte: k[7:6] buf[5] pol[4] dt[3] lo_en[2] hi_en[1] run[0]
  function automatic logic [7:0] mk_ctrl(input logic run, input logic [1:0] k,
                                         input logic dt, input logic pol, input logic bf);
    return {k, bf, pol, dt, 1'b1, 1'b1, run};
  endfunction

  task automatic set_duty(input int p, input int d);
    wr(4'(4 + 2*p), 8'(d >> 2));
    wr(4'(5 + 2*p), 8'(d & 3));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic pin(input int sel);
    return (sel < 3) ? pwm_hi[sel] : pwm_lo[sel-3];
  endfunction

  // length of the next complete run of level lvl on a pin, -1 on timeout
  task automatic run_len(input int sel, input logic lvl, output int w);
    int t;
    w = -1; t = 0;
    while (pin(sel) == lvl && t < 3000) begin @(negedge clk); t++; end
    while (pin(sel) != lvl && t < 6000) begin @(negedge clk); t++; end
    if (t >= 6000) return;
    w = 0;
    while (pin(sel) == lvl && w < 3000) begin w++; @(negedge clk); end
  endtask

  task automatic irq_gap(output int n);
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    @(negedge clk);
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    n = n + 1;
  endtask

  task automatic t_reset;
    idle(2);
    chk(int'({pwm_hi, pwm_lo}), 0, "R1 reset pins");
    chk(int'(irq), 0, "R1 reset irq");
  endtask

  task automatic t_irq;
    int n;
    wr(0, mk_ctrl(1'b1, 2'd3, 1'b0, 1'b0, 1'b0));
    wr(1, 8'h00);
    irq_gap(n); irq_gap(n);
    chk(n, 128, "R3 R5 irq period k=3 ps=0");
    @(negedge clk);
    chk(int'(irq), 0, "R5 irq single clock");
    wr(0, mk_ctrl(1'b1, 2'd1, 1'b0, 1'b0, 1'b0));
    wr(1, 8'h01);
    irq_gap(n); irq_gap(n);
    chk(n, 1024, "R2 R3 irq period k=1 ps=1");
    wr(1, 8'h00);
  endtask

  task automatic t_width;
    int w, s, bad;
    wr(2, 8'h3F);
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    set_duty(0, 20);
    idle(2100);
    run_len(0, 1'b1, w); chk(w, 20, "R4 width k=0 duty=20");
    run_len(3, 1'b1, w); chk(w, 1004, "R6 low side complement");
    wr(0, mk_ctrl(1'b1, 2'd1, 1'b0, 1'b0, 1'b0));
    idle(2100);
    run_len(0, 1'b1, w); chk(w, 10, "R4 width k=1 duty=0x014");
    wr(0, mk_ctrl(1'b1, 2'd2, 1'b0, 1'b0, 1'b0));
    set_duty(0, 23);
    idle(2100);
    s = 0; bad = 0;
    for (int i = 0; i < 4; i++) begin
      run_len(0, 1'b1, w);
      s += w;
      if (w != 5 && w != 6) bad++;
    end
    chk(s, 23, "R4 dither sum over full cycle");
    chk(bad, 0, "R4 dither widths 5 or 6");
  endtask

  task automatic t_dead;
    int w, n, ov;
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b1, 1'b0, 1'b0));
    wr(1, 8'h48);            // length code 2, clock code 1 -> 6 clocks
    set_duty(0, 20);
    idle(2100);
    run_len(0, 1'b1, w); chk(w, 14, "R7 high pulse shortened by gap");
    n = 0; ov = 0;
    while (pwm_hi[0] != 1'b0) @(negedge clk);
    while (pwm_lo[0] == 1'b0 && n < 100) begin
      if (pwm_hi[0]) ov++;
      n++; @(negedge clk);
    end
    chk(n, 6, "R7 gap after high side falls");
    chk(ov, 0, "R6 high stays off in gap");
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    idle(4);
    chk(int'(pwm_hi[0] ^ pwm_lo[0]), 1, "R7 no gap when disabled");
  endtask

  task automatic t_pol;
    int w;
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b0, 1'b1, 1'b0));
    set_duty(0, 20);
    idle(2100);
    run_len(0, 1'b0, w); chk(w, 20, "R8 low-active high side width");
    run_len(3, 1'b0, w); chk(w, 1004, "R8 low-active low side width");
  endtask

  task automatic t_gate;
    int seen0, seen1, n;
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b1, 1'b0, 1'b0));
    wr(1, 8'h48);
    set_duty(0, 0);
    set_duty(1, 40);
    wr(2, 8'h3D);            // low side of leg 0 not passed
    idle(1100);
    seen0 = 0; seen1 = 0;
    for (int i = 0; i < 1100; i++) begin
      if (pwm_hi[0] || pwm_lo[0]) seen0++;
      if (pwm_hi[1]) seen1 = 1;
      @(negedge clk);
    end
    chk(seen0, 0, "R9 leg with one pin blocked stays inactive");
    chk(seen1, 1, "R9 other leg keeps switching");
    wr(2, 8'h3F);
    n = 0;
    while (!pwm_lo[0] && !pwm_hi[0] && n < 100) begin n++; @(negedge clk); end
    chk(n, 6, "R9 gap applied on re-enable");
    chk(int'(pwm_lo[0]), 1, "R9 low side on after re-enable, duty 0");
    wr(0, mk_ctrl(1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
    idle(3);
    chk(int'({pwm_hi, pwm_lo}), 0, "R9 run clear forces inactive");
    wr(0, mk_ctrl(1'b0, 2'd0, 1'b1, 1'b1, 1'b0));
    idle(3);
    chk(int'({pwm_hi, pwm_lo}), 63, "R8 inactive level follows polarity");
  endtask

  task automatic t_buf;
    int w, hi_seen;
    wr(1, 8'h00);
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b1));
    set_duty(0, 100);
    idle(2100);
    while (!irq) @(negedge clk);
    idle(500);
    wr(4, 8'(700 >> 2));
    hi_seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwm_hi[0]) hi_seen = 1;
      @(negedge clk);
    end
    chk(hi_seen, 0, "R10 buffered write held until cycle end");
    run_len(0, 1'b1, w); chk(w, 700, "R10 buffered value applied next cycle");
    wr(0, mk_ctrl(1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    set_duty(0, 100);
    idle(2100);
    while (!irq) @(negedge clk);
    idle(500);
    wr(4, 8'(700 >> 2));
    idle(5);
    chk(int'(pwm_hi[0]), 1, "R10 immediate write takes effect");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset;
    t_irq;
    t_width;
    t_dead;
    t_pol;
    t_gate;
    t_buf;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule